// File: doc/BRIEF.md
# 64-bit MII Receive Frame Extractor

This block sits behind a PCS-only Ethernet receive path. Each input word is eight bytes wide, one control flag per byte. The block finds frames in that stream and passes their payload on as 64-bit words, marked with start, end and byte-enable. It opens a frame only on a start character in byte lane 0. In that start word it checks the seven bytes of preamble and delimiter. It closes the frame at the first terminate character and marks any control character that sits inside the frame as an error.

Input words count only when the valid strobe is high. A word flagged as an alignment marker is consumed with no output and no change of frame state, even in the middle of a frame. Lane 0 is the earliest byte in time. The output is registered, so data appears one cycle after the word is accepted.

Back-pressure rule: the output stream has no ready signal. The consumer must take every cycle in which `rx_vld` is high. The input side has no ready either: every qualified word is consumed in the cycle it is offered.

Top module: `mrx_frame_extract`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rx_vld` and `sof_err` are low.
- R2: A cycle with `mii_vld` low produces no output and does not change the frame state. The words before and after it are processed as if the gap were absent.
- R3: A frame opens on an accepted word with control flag 1 and byte 0xFB in lane 0, bytes 0x55 in lanes 1 to 6 and 0xD5 in lane 7, and control flags 0 in lanes 1 to 7. That start word produces no output. The next payload word that is output carries `rx_sop`.
- R4: A word with 0xFB under a control flag in lane 0 but any wrong byte or a set control flag in lanes 1 to 7 opens no frame. One cycle later it raises `sof_err` for exactly one cycle.
- R5: Inside a frame, a word with no terminate is output one cycle later with all eight byte-enables set, its data unchanged, and `rx_eop` and `rx_err` low.
- R6: Inside a frame, the first lane t that holds 0xFD with its control flag set ends the frame. That word is output with `rx_eop` set and `rx_be` equal to 2^t-1 (bit i enables lane i). Data bytes in disabled lanes are zero. For t = 0 the byte-enable is zero.
- R7: A control character other than 0xFD inside a frame and before the terminate sets `rx_err` on the frame's final word only. This includes 0xFE and an idle. `rx_err` is never set without `rx_eop`.
- R8: Outside a frame, words without a start character in lane 0 produce no output. Idle words (0x07 with control flags set) are one such case.
- R9: A start character in lane 0 of a word inside a frame closes the current frame. That closing word has `rx_eop` and `rx_err` set and a zero byte-enable. The same word is then judged as a start word under R3/R4.
- R10: An accepted word with `mii_am` high produces no output and leaves the frame state, the pending start mark and the error state unchanged.
- R11: `rx_sop`, `rx_eop` and `rx_err` are only ever high together with `rx_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mii_vld | input | 1 | Qualifies the input word |
| mii_am | input | 1 | Word is an alignment marker (sampled with `mii_vld`) |
| mii_data | input | 64 | Eight byte lanes, lane 0 in bits 7:0 |
| mii_ctl | input | 8 | Control flag per lane, 1 = control character |
| rx_vld | output | 1 | Output word valid |
| rx_data | output | 64 | Payload bytes, disabled lanes zero |
| rx_be | output | 8 | Byte-enable per lane |
| rx_sop | output | 1 | First word of a frame |
| rx_eop | output | 1 | Last word of a frame |
| rx_err | output | 1 | Frame contained an error (final word only) |
| sof_err | output | 1 | One-cycle pulse for a bad preamble or delimiter |

## Verification
Directed frames place the terminate in lane 0, in a middle lane and in lane 7, to tell the mask arithmetic apart from an off-by-one. Start words with one corrupted byte, and with a stray control flag, separate the delimiter check from a plain lane-0 match. Valid gaps and alignment-marker words are dropped into the middle of frames and between the start word and the first payload word. This shows whether frame state and the pending start mark survive them. Random frames mix payload lengths, injected 0xFE bytes, restarts inside a frame and idle runs. Every word is checked against a model in the bench.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  localparam int LANE_W = 8;
  localparam logic [LANE_W-1:0] CH_START = 8'hFB;
  localparam logic [LANE_W-1:0] CH_TERM  = 8'hFD;
  localparam logic [LANE_W-1:0] CH_ERROR = 8'hFE;
  localparam logic [LANE_W-1:0] CH_IDLE  = 8'h07;
  localparam logic [LANE_W-1:0] BY_PRE   = 8'h55;
  localparam logic [LANE_W-1:0] BY_SFD   = 8'hD5;
endpackage

// File: rtl/mrx_lane_class.sv
module mrx_lane_class #(
  parameter int LANES = 8
) (
  input  logic [LANES*mrx_pkg::LANE_W-1:0] data,
  input  logic [LANES-1:0]                 ctl,
  output logic [LANES-1:0]                 is_term,
  output logic [LANES-1:0]                 is_bad,
  output logic                             start0
);
  localparam int LW = mrx_pkg::LANE_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] byte_i;
    assign byte_i     = data[i*LW +: LW];
    assign is_term[i] = ctl[i] && (byte_i == mrx_pkg::CH_TERM);
    // any control character that is not a terminate is an in-frame fault
    assign is_bad[i]  = ctl[i] && (byte_i != mrx_pkg::CH_TERM);
  end

  assign start0 = ctl[0] && (data[LW-1:0] == mrx_pkg::CH_START);
endmodule

// File: rtl/mrx_sof_check.sv
module mrx_sof_check #(
  parameter int LANES = 8
) (
  input  logic [LANES*mrx_pkg::LANE_W-1:0] data,
  input  logic [LANES-1:0]                 ctl,
  output logic                             sof_ok
);
  localparam int LW = mrx_pkg::LANE_W;
  logic [LANES-1:0] lane_ok;

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    if (i == 0) begin : g_first
      assign lane_ok[i] = ctl[i] && (data[LW-1:0] == mrx_pkg::CH_START);
    end else if (i == LANES-1) begin : g_sfd
      assign lane_ok[i] = !ctl[i] && (data[i*LW +: LW] == mrx_pkg::BY_SFD);
    end else begin : g_pre
      assign lane_ok[i] = !ctl[i] && (data[i*LW +: LW] == mrx_pkg::BY_PRE);
    end
  end

  assign sof_ok = &lane_ok;
endmodule

// File: rtl/mrx_term_scan.sv
module mrx_term_scan #(
  parameter int LANES = 8
) (
  input  logic [LANES-1:0] is_term,
  input  logic [LANES-1:0] is_bad,
  output logic             found,
  output logic [LANES-1:0] keep,
  output logic             prefix_bad
);
  // lanes are walked in arrival order; everything at or after the first
  // terminate is dropped
  always_comb begin
    logic seen;
    seen       = 1'b0;
    prefix_bad = 1'b0;
    keep       = '0;
    for (int i = 0; i < LANES; i++) begin
      keep[i]    = !seen;
      seen       = seen | is_term[i];
      if (keep[i] && !is_term[i]) prefix_bad = prefix_bad | is_bad[i];
      if (is_term[i]) keep[i] = 1'b0;
    end
    found = seen;
  end
endmodule

// File: rtl/mrx_frame_extract.sv
module mrx_frame_extract #(
  parameter int LANES = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             mii_vld,
  input  logic                             mii_am,
  input  logic [LANES*mrx_pkg::LANE_W-1:0] mii_data,
  input  logic [LANES-1:0]                 mii_ctl,
  output logic                             rx_vld,
  output logic [LANES*mrx_pkg::LANE_W-1:0] rx_data,
  output logic [LANES-1:0]                 rx_be,
  output logic                             rx_sop,
  output logic                             rx_eop,
  output logic                             rx_err,
  output logic                             sof_err
);
  localparam int LW = mrx_pkg::LANE_W;
  localparam int DW = LANES * LW;
  localparam logic [LANES-1:0] ONE_L = {{(LANES-1){1'b0}}, 1'b1};

  logic [LANES-1:0] is_term, is_bad, keep;
  logic             start0, sof_ok, found, prefix_bad;

  mrx_lane_class #(.LANES(LANES)) u_class (
    .data(mii_data), .ctl(mii_ctl),
    .is_term(is_term), .is_bad(is_bad), .start0(start0)
  );

  mrx_sof_check #(.LANES(LANES)) u_sof (
    .data(mii_data), .ctl(mii_ctl), .sof_ok(sof_ok)
  );

  mrx_term_scan #(.LANES(LANES)) u_scan (
    .is_term(is_term), .is_bad(is_bad),
    .found(found), .keep(keep), .prefix_bad(prefix_bad)
  );

  // frame state
  logic in_frame, sop_pend, err_acc;
  logic in_frame_n, sop_pend_n, err_acc_n;

  // next output
  logic          vld_n, sop_n, eop_n, err_n, pe_n;
  logic [LANES-1:0] be_n;
  logic [DW-1:0] data_n;

  logic take;
  assign take = mii_vld && !mii_am;

  always_comb begin
    in_frame_n = in_frame;
    sop_pend_n = sop_pend;
    err_acc_n  = err_acc;
    vld_n = 1'b0;
    sop_n = 1'b0;
    eop_n = 1'b0;
    err_n = 1'b0;
    pe_n  = 1'b0;
    be_n  = '0;
    if (take) begin
      if (in_frame) begin
        vld_n      = 1'b1;
        sop_n      = sop_pend;
        sop_pend_n = 1'b0;
        if (start0) begin
          // restart: close the running frame as failed
          eop_n      = 1'b1;
          err_n      = 1'b1;
          in_frame_n = 1'b0;
        end else begin
          be_n      = keep;
          err_acc_n = err_acc | prefix_bad;
          if (found) begin
            eop_n      = 1'b1;
            err_n      = err_acc | prefix_bad;
            in_frame_n = 1'b0;
          end
        end
      end
      if (start0) begin
        if (sof_ok) begin
          in_frame_n = 1'b1;
          sop_pend_n = 1'b1;
          err_acc_n  = 1'b0;
        end else begin
          pe_n = 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign data_n[i*LW +: LW] = be_n[i] ? mii_data[i*LW +: LW] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      sop_pend <= 1'b0;
      err_acc  <= 1'b0;
      rx_vld   <= 1'b0;
      rx_sop   <= 1'b0;
      rx_eop   <= 1'b0;
      rx_err   <= 1'b0;
      sof_err  <= 1'b0;
      rx_be    <= '0;
      rx_data  <= '0;
    end else begin
      in_frame <= in_frame_n;
      sop_pend <= sop_pend_n;
      err_acc  <= err_acc_n;
      rx_vld   <= vld_n;
      rx_sop   <= sop_n;
      rx_eop   <= eop_n;
      rx_err   <= err_n;
      sof_err  <= pe_n;
      if (vld_n) begin
        rx_be   <= be_n;
        rx_data <= data_n;
      end
    end
  end

  // R1: quiet output during and right after reset
  p_quiet_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!rx_vld && !sof_err));

  // R2: a gap cycle emits nothing and freezes the frame state
  p_gap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mii_vld |=> (!rx_vld && !sof_err && $stable(in_frame) && $stable(sop_pend)));

  // R4: a delimiter fault never leaves a frame open
  p_bad_sof_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sof_err |-> !in_frame);

  // R6: byte enables form a contiguous run from lane 0
  p_be_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |-> ((rx_be & (rx_be + ONE_L)) == '0));

  // R7: the error flag only rides on the final word
  p_err_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> rx_eop);

  // R10: alignment-marker words are invisible
  p_am_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mii_vld && mii_am) |=> (!rx_vld && !sof_err && $stable(in_frame)
                              && $stable(sop_pend) && $stable(err_acc)));

  // R11: markers only with a valid word
  p_marks_vld_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sop || rx_eop || rx_err) |-> rx_vld);
endmodule

// File: tb/mrx_frame_extract_tb.sv
module mrx_frame_extract_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mii_vld = 1'b0, mii_am = 1'b0;
  logic [63:0] mii_data = '0;
  logic [7:0]  mii_ctl = '0;
  logic        rx_vld, rx_sop, rx_eop, rx_err, sof_err;
  logic [63:0] rx_data;
  logic [7:0]  rx_be;

  always #4 clk = ~clk;  // 125 MHz

  mrx_frame_extract u_dut (
    .clk(clk), .rst_n(rst_n), .mii_vld(mii_vld), .mii_am(mii_am),
    .mii_data(mii_data), .mii_ctl(mii_ctl),
    .rx_vld(rx_vld), .rx_data(rx_data), .rx_be(rx_be), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .rx_err(rx_err), .sof_err(sof_err)
  );

  int n_vec = 0, n_bad = 0;
  bit m_in = 0, m_sop = 0, m_err = 0;

  localparam logic [63:0] GOOD_SOF = 64'hD5555555_555555FB;

  task automatic check(input string tag, input logic [83:0] act, input logic [83:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // apply one input word, predict, compare after the edge
  task automatic apply(input bit v, input bit am, input logic [63:0] d, input logic [7:0] c);
    logic [63:0] e_data = '0;
    logic [7:0]  e_be = '0;
    bit e_vld = 0, e_sop = 0, e_eop = 0, e_err = 0, e_pe = 0, st, ok, hit;
    string tag;
    @(negedge clk);
    mii_vld = v; mii_am = am; mii_data = d; mii_ctl = c;
    tag = am ? "R10" : "R2";
    if (v && !am) begin
      st = c[0] && d[7:0] == 8'hFB;
      ok = st;
      for (int i = 1; i < 8; i++)
        if (c[i] || d[i*8 +: 8] != ((i == 7) ? 8'hD5 : 8'h55)) ok = 0;
      tag = "R8";
      if (m_in) begin
        e_vld = 1; e_sop = m_sop; m_sop = 0;
        if (st) begin
          e_eop = 1; e_err = 1; m_in = 0; tag = "R9";
        end else begin
          hit = 0;
          for (int i = 0; i < 8; i++)
            if (!hit) begin
              if (c[i] && d[i*8 +: 8] == 8'hFD) hit = 1;
              else begin
                e_be[i] = 1; e_data[i*8 +: 8] = d[i*8 +: 8];
                if (c[i]) m_err = 1;
              end
            end
          if (hit) begin
            e_eop = 1; e_err = m_err; m_in = 0;
            tag = m_err ? "R7" : "R6";
          end else tag = e_sop ? "R3" : "R5";
        end
      end
      if (st) begin
        if (ok) begin m_in = 1; m_sop = 1; m_err = 0; if (tag == "R8") tag = "R3"; end
        else begin e_pe = 1; if (tag == "R8") tag = "R4"; end
      end
    end
    @(posedge clk); #1;
    // R11: markers are compared together with valid
    if (e_vld)
      check(tag, {rx_vld, sof_err, rx_sop, rx_eop, rx_err, 1'b0, rx_be, rx_data},
                 {e_vld,  e_pe,    e_sop,  e_eop,  e_err,  1'b0, e_be,  e_data});
    else
      check(tag, {82'd0, rx_vld, sof_err}, {82'd0, 1'b0, e_pe});
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic payload(); apply(1, 0, rnd64(), 8'h00); endtask
  task automatic sof();     apply(1, 0, GOOD_SOF, 8'h01); endtask
  task automatic idle();    apply(1, 0, {8{8'h07}}, 8'hFF); endtask

  task automatic term(input int t);
    logic [63:0] d = rnd64();
    logic [7:0]  c = '0;
    for (int i = 0; i < 8; i++) begin
      if (i == t) begin d[i*8 +: 8] = 8'hFD; c[i] = 1; end
      else if (i > t) begin d[i*8 +: 8] = 8'h07; c[i] = 1; end
    end
    apply(1, 0, d, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1 check("R1", {82'd0, rx_vld, sof_err}, 84'd0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1 check("R1", {82'd0, rx_vld, sof_err}, 84'd0);

    // directed corners
    idle(); apply(1, 0, rnd64(), 8'h00);                   // R8
    sof(); payload(); payload(); term(3);                   // R3 R5 R6
    sof(); term(0);                                         // R6 t=0
    sof(); payload(); term(7);                              // R6 t=7
    sof(); apply(1, 0, 64'h0123_4567_FE89_ABCD, 8'h08); payload(); term(2); // R7
    apply(1, 0, GOOD_SOF ^ 64'h0000_0100_0000_0000, 8'h01); // R4 bad byte
    apply(1, 0, GOOD_SOF, 8'h05);                           // R4 ctl flag
    payload();                                              // nothing open
    sof(); apply(1, 1, rnd64(), 8'hFF); apply(0, 0, rnd64(), 8'h3C);
    payload(); apply(1, 1, rnd64(), 8'h00); apply(0, 1, rnd64(), 8'h01); term(5); // R10 R2
    sof(); payload(); sof(); payload(); term(4);             // R9 restart
    sof(); apply(1, 0, GOOD_SOF ^ 64'h1, 8'h01);             // bad start as word lane0 not FB
    term(1);
    sof(); apply(1, 0, GOOD_SOF ^ 64'h0100, 8'h01); payload(); // R9 restart, bad R4

    // random frames
    for (int f = 0; f < 400; f++) begin
      int nw, r;
      r = $urandom_range(0, 7);
      if (r == 0) apply(1, 0, GOOD_SOF ^ (64'h1 << $urandom_range(8, 63)), 8'h01);
      else if (r == 1) apply(1, 0, GOOD_SOF, 8'h01 | (8'h1 << $urandom_range(1, 7)));
      else sof();
      nw = $urandom_range(0, 4);
      for (int w = 0; w < nw; w++) begin
        if ($urandom_range(0, 4) == 0) apply(0, $urandom_range(0, 1), rnd64(), 8'($urandom));
        if ($urandom_range(0, 5) == 0) apply(1, 1, rnd64(), 8'($urandom));
        if ($urandom_range(0, 5) == 0) begin
          logic [63:0] d = rnd64();
          int k = $urandom_range(0, 7);
          d[k*8 +: 8] = ($urandom_range(0, 1) != 0) ? 8'hFE : 8'h07;
          apply(1, 0, d, 8'h1 << k);
        end else payload();
      end
      if ($urandom_range(0, 9) == 0) sof();
      else term($urandom_range(0, 7));
      for (int g = 0; g < $urandom_range(0, 2); g++) idle();
    end
    term(3);
    apply(0, 0, '0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule